// File: doc/BRIEF.md
# Multichannel I/Q Mixer and Decimator

The block down-converts a group of signed ADC channels that arrive side by side in one wide word. Every channel is multiplied by the same cosine and sine local-oscillator samples. Each product is rescaled and clamped to a mixer width that keeps a few guard bits. It then enters its own second-order CIC averager. The averager integrates every cycle and forms its two comb differences once per decimation period. The period and an extra output shift are plain run-time controls.

At each period boundary the in-phase results of all channels load in parallel into one shift register, and the quadrature results load into a second one. Each register drains as its own valid/ready stream, channel 0 first, one channel per accepted beat. The two streams are independent. Holding `i_ready` low stalls only the in-phase stream, and holding `q_ready` low stalls only the quadrature stream. While a stream is stalled, its data and valid stay frozen. A new period boundary always reloads both registers, so entries not yet sent are replaced by the fresh frame.

Top module: `iq_conveyor`

## Requirements
- R1: While `rst` is high, and after it falls until the first period boundary, `i_valid` and `q_valid` are low.
- R2: The in-phase lane uses `lo_cos` and the quadrature lane uses `lo_sin`. Channel n is the signed slice `adc_bus[n*DW +: DW]`. The mixer value is (sample × oscillator) arithmetically shifted right by DW+OSCW-1-MIXW, where MIXW = DW+GUARD, then clamped to MIXW signed bits.
- R3: With a constant `period` P greater than NCH and both readies high, a frame starts on the streams once every P cycles.
- R4: For a mixer value x that has been constant for at least three periods, each result equals floor(x·P² / 2^(SHIFT_BASE+`shift_ctl`)).
- R5: A result outside the RESW-bit signed range is clamped to the nearest bound instead of wrapping.
- R6: A frame holds NCH beats on each stream, channel 0 first. With ready held high, these beats are on consecutive cycles, and valid is low again once the frame is done.
- R7: While valid is high and ready is low, and no boundary occurs, the stream keeps valid high and its data unchanged. No beat is lost.
- R8: A period boundary reloads a stream even if it still holds unsent entries. That stream then delivers a complete new frame, starting at channel 0. Valid rises only in the cycle after a boundary load.
- R9: Stalling one stream has no effect on the timing or values of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_bus | input | NCH*DW | Packed signed samples, channel n in bits n*DW upward |
| lo_cos | input | OSCW | Signed cosine oscillator sample, shared |
| lo_sin | input | OSCW | Signed sine oscillator sample, shared |
| period | input | PERW | Decimation period in cycles |
| shift_ctl | input | 4 | Extra output right shift, added to SHIFT_BASE |
| i_data | output | RESW | In-phase stream data, signed |
| i_valid | output | 1 | In-phase stream valid |
| i_ready | input | 1 | In-phase stream ready |
| q_data | output | RESW | Quadrature stream data, signed |
| q_valid | output | 1 | Quadrature stream valid |
| q_ready | input | 1 | Quadrature stream ready |

## Verification
The bench builds the block with three 8-bit channels, 8-bit oscillators, three guard bits, a 24-bit accumulator, 12-bit results, a 6-bit period and a base shift of 2. At these sizes the bench can compute x·P² exactly in plain integer arithmetic. The sizes also let mixer clamping (most negative times most negative) and result clamping both happen with ordinary inputs. They also make a sweep of every period from 4 to 20, each paired with its own shift, cheap to run. The short frames let back-pressure and mid-frame reload be checked beat by beat against distinct per-channel values.

// File: rtl/iq_conveyor_pkg.sv
package iq_conveyor_pkg;
  localparam int SHIFT_CTLW = 4;

  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/iq_dump_timer.sv
module iq_dump_timer #(
  parameter int PERW = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PERW-1:0] period,
  output logic            dump
);
  logic [PERW-1:0] cnt;
  logic [PERW:0]   cnt_inc;

  // the last count of a period is the one whose successor reaches period
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign dump    = (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (dump) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/iq_mixer.sv
module iq_mixer
  import iq_conveyor_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 16,
  parameter int OSCW = 18,
  parameter int MIXW = 19
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH*DW-1:0]         adc_bus,
  input  logic [OSCW-1:0]           lo_cos,
  input  logic [OSCW-1:0]           lo_sin,
  output logic [NCH-1:0][MIXW-1:0]  mix_i,
  output logic [NCH-1:0][MIXW-1:0]  mix_q
);
  localparam int PW  = DW + OSCW;
  localparam int PSH = DW + OSCW - 1 - MIXW;
  localparam logic signed [PW-1:0] MMAX = PW'((2 ** (MIXW - 1)) - 1);
  localparam logic signed [PW-1:0] MMIN = ~MMAX;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [OSCW-1:0] osc;
    if (l == int'(LANE_I)) begin : g_cos
      assign osc = lo_cos;
    end else begin : g_sin
      assign osc = lo_sin;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [DW-1:0]   smp;
      logic signed [PW-1:0]   prod;
      logic signed [PW-1:0]   scaled;
      logic        [MIXW-1:0] clamped;

      assign smp    = adc_bus[c*DW +: DW];
      assign prod   = smp * osc;
      assign scaled = prod >>> PSH;

      always_comb begin
        if (scaled > MMAX) begin
          clamped = MMAX[MIXW-1:0];
        end else if (scaled < MMIN) begin
          clamped = MMIN[MIXW-1:0];
        end else begin
          clamped = scaled[MIXW-1:0];
        end
      end

      if (l == int'(LANE_I)) begin : g_to_i
        always_ff @(posedge clk) begin
          if (rst) mix_i[c] <= '0;
          else     mix_i[c] <= clamped;
        end
      end else begin : g_to_q
        always_ff @(posedge clk) begin
          if (rst) mix_q[c] <= '0;
          else     mix_q[c] <= clamped;
        end
      end
    end
  end
endmodule

// File: rtl/iq_cic2.sv
module iq_cic2
  import iq_conveyor_pkg::*;
#(
  parameter int MIXW       = 19,
  parameter int ACCW       = 28,
  parameter int RESW       = 20,
  parameter int SHIFT_BASE = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MIXW-1:0]       mix,
  input  logic                  dump,
  input  logic [SHIFT_CTLW-1:0] shift_ctl,
  output logic [RESW-1:0]       res
);
  localparam logic signed [ACCW-1:0] RMAX = ACCW'((2 ** (RESW - 1)) - 1);
  localparam logic signed [ACCW-1:0] RMIN = ~RMAX;

  logic signed [ACCW-1:0] xin;
  logic signed [ACCW-1:0] integ1, integ2;
  logic signed [ACCW-1:0] held, diff1, diff2;
  logic signed [ACCW-1:0] first_diff;
  logic signed [ACCW-1:0] shifted;

  assign xin        = ACCW'($signed(mix));
  assign first_diff = integ2 - held;

  // integrators run every cycle and wrap modulo 2^ACCW
  always_ff @(posedge clk) begin
    if (rst) begin
      integ1 <= '0;
      integ2 <= '0;
    end else begin
      integ1 <= integ1 + xin;
      integ2 <= integ2 + integ1;
    end
  end

  // comb pair evaluated once per period
  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      diff1 <= '0;
      diff2 <= '0;
    end else if (dump) begin
      held  <= integ2;
      diff1 <= first_diff;
      diff2 <= first_diff - diff1;
    end
  end

  assign shifted = diff2 >>> (SHIFT_BASE + int'(shift_ctl));

  always_comb begin
    if (shifted > RMAX) begin
      res = RMAX[RESW-1:0];
    end else if (shifted < RMIN) begin
      res = RMIN[RESW-1:0];
    end else begin
      res = shifted[RESW-1:0];
    end
  end
endmodule

// File: rtl/iq_belt.sv
module iq_belt #(
  parameter int NCH = 8,
  parameter int W   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NCH-1:0][W-1:0] din,
  output logic [W-1:0]         out_data,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int CW = $clog2(NCH + 1);

  logic [NCH-1:0][W-1:0] slots;
  logic [NCH-1:0][W-1:0] slots_adv;
  logic [CW-1:0]         left;

  for (genvar k = 0; k < NCH; k++) begin : g_adv
    if (k == NCH - 1) begin : g_tail
      assign slots_adv[k] = '0;
    end else begin : g_body
      assign slots_adv[k] = slots[k+1];
    end
  end

  assign out_valid = (left != '0);
  assign out_data  = slots[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
      left  <= '0;
    end else if (load) begin
      slots <= din;
      left  <= CW'(NCH);
    end else if (out_valid && out_ready) begin
      slots <= slots_adv;
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/iq_conveyor.sv
module iq_conveyor
  import iq_conveyor_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 16,
  parameter int OSCW       = 18,
  parameter int GUARD      = 3,
  parameter int ACCW       = 28,
  parameter int RESW       = 20,
  parameter int PERW       = 13,
  parameter int SHIFT_BASE = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*DW-1:0]     adc_bus,
  input  logic [OSCW-1:0]       lo_cos,
  input  logic [OSCW-1:0]       lo_sin,
  input  logic [PERW-1:0]       period,
  input  logic [SHIFT_CTLW-1:0] shift_ctl,
  output logic [RESW-1:0]       i_data,
  output logic                  i_valid,
  input  logic                  i_ready,
  output logic [RESW-1:0]       q_data,
  output logic                  q_valid,
  input  logic                  q_ready
);
  localparam int MIXW = DW + GUARD;

  logic [NCH-1:0][MIXW-1:0] mix_i, mix_q;
  logic [NCH-1:0][RESW-1:0] res_i, res_q;
  logic                     dump;
  logic                     belt_load;

  iq_dump_timer #(.PERW(PERW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .period (period),
    .dump   (dump)
  );

  iq_mixer #(.NCH(NCH), .DW(DW), .OSCW(OSCW), .MIXW(MIXW)) u_mixer (
    .clk     (clk),
    .rst     (rst),
    .adc_bus (adc_bus),
    .lo_cos  (lo_cos),
    .lo_sin  (lo_sin),
    .mix_i   (mix_i),
    .mix_q   (mix_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iq_cic2 #(.MIXW(MIXW), .ACCW(ACCW), .RESW(RESW), .SHIFT_BASE(SHIFT_BASE)) u_cic_i (
      .clk       (clk),
      .rst       (rst),
      .mix       (mix_i[c]),
      .dump      (dump),
      .shift_ctl (shift_ctl),
      .res       (res_i[c])
    );
    iq_cic2 #(.MIXW(MIXW), .ACCW(ACCW), .RESW(RESW), .SHIFT_BASE(SHIFT_BASE)) u_cic_q (
      .clk       (clk),
      .rst       (rst),
      .mix       (mix_q[c]),
      .dump      (dump),
      .shift_ctl (shift_ctl),
      .res       (res_q[c])
    );
  end

  // comb registers settle one cycle after the boundary; load the belts then
  always_ff @(posedge clk) begin
    if (rst) belt_load <= 1'b0;
    else     belt_load <= dump;
  end

  iq_belt #(.NCH(NCH), .W(RESW)) u_belt_i (
    .clk       (clk),
    .rst       (rst),
    .load      (belt_load),
    .din       (res_i),
    .out_data  (i_data),
    .out_valid (i_valid),
    .out_ready (i_ready)
  );

  iq_belt #(.NCH(NCH), .W(RESW)) u_belt_q (
    .clk       (clk),
    .rst       (rst),
    .load      (belt_load),
    .din       (res_q),
    .out_data  (q_data),
    .out_valid (q_valid),
    .out_ready (q_ready)
  );
endmodule

// File: rtl/iq_conveyor_chk.sv
module iq_conveyor_chk #(
  parameter int W    = 20,
  parameter int PERW = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic            dump,
  input logic [PERW-1:0] period,
  input logic [W-1:0]    i_data,
  input logic            i_valid,
  input logic            i_ready,
  input logic [W-1:0]    q_data,
  input logic            q_valid,
  input logic            q_ready
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!i_valid && !q_valid));

  assert_i_from_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(i_valid) |-> $past(load));

  assert_q_from_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid) |-> $past(load));

  assert_i_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (i_valid && !i_ready && !load) |=> (i_valid && $stable(i_data)));

  assert_q_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready && !load) |=> (q_valid && $stable(q_data)));

  assert_dump_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (dump && $past(dump) && $stable(period)) |-> (period <= PERW'(1)));
endmodule

bind iq_conveyor iq_conveyor_chk #(.W(RESW), .PERW(PERW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (belt_load),
  .dump    (dump),
  .period  (period),
  .i_data  (i_data),
  .i_valid (i_valid),
  .i_ready (i_ready),
  .q_data  (q_data),
  .q_valid (q_valid),
  .q_ready (q_ready)
);

// File: tb/sim_iq_conveyor.sv
`timescale 1ns/1ps
module sim_iq_conveyor;
  localparam int NCH  = 3;
  localparam int DW   = 8;
  localparam int OSCW = 8;
  localparam int RESW = 12;
  localparam int PERW = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCH*DW-1:0] adc_bus;
  logic [OSCW-1:0]   lo_cos, lo_sin;
  logic [PERW-1:0]   period;
  logic [3:0]        shift_ctl;
  logic [RESW-1:0]   i_data, q_data;
  logic              i_valid, q_valid, i_ready, q_ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iq_conveyor #(
    .NCH(NCH), .DW(DW), .OSCW(OSCW), .GUARD(3), .ACCW(24),
    .RESW(RESW), .PERW(PERW), .SHIFT_BASE(2)
  ) u0 (
    .clk(clk), .rst(rst), .adc_bus(adc_bus), .lo_cos(lo_cos), .lo_sin(lo_sin),
    .period(period), .shift_ctl(shift_ctl),
    .i_data(i_data), .i_valid(i_valid), .i_ready(i_ready),
    .q_data(q_data), .q_valid(q_valid), .q_ready(q_ready)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mixer model: shift by DW+OSCW-1-MIXW = 4, clamp to 11 signed bits
  function automatic longint mixv(input longint a, input longint c);
    longint p;
    p = (a * c) >>> 4;
    if (p > 1023) p = 1023;
    if (p < -1024) p = -1024;
    return p;
  endfunction

  function automatic longint resv(input longint x, input longint n, input longint s);
    longint r;
    r = (x * n * n) >>> (2 + s);
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  function automatic bit clipped(input longint x, input longint n, input longint s);
    longint r;
    r = (x * n * n) >>> (2 + s);
    return (r > 2047) || (r < -2048);
  endfunction

  task automatic frame_both(output longint iv[NCH], output longint qv[NCH], output int t0);
    while (!i_valid) @(negedge clk);
    t0 = cyc;
    for (int k = 0; k < NCH; k++) begin
      chk("R6 i beat valid", longint'(i_valid), 1);
      chk("R6 q beat valid", longint'(q_valid), 1);
      iv[k] = longint'($signed(i_data));
      qv[k] = longint'($signed(q_data));
      @(negedge clk);
    end
    chk("R6 i frame end", longint'(i_valid), 0);
    chk("R6 q frame end", longint'(q_valid), 0);
  endtask

  task automatic collect_lane(input bit ql, output longint v[NCH]);
    while (!(ql ? q_valid : i_valid)) @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      chk("R6 lane beat valid", longint'(ql ? q_valid : i_valid), 1);
      v[k] = longint'($signed(ql ? q_data : i_data));
      @(negedge clk);
    end
    chk("R6 lane frame end", longint'(ql ? q_valid : i_valid), 0);
  endtask

  longint ai[NCH];
  longint ci, si;

  task automatic run_case(input longint a0, input longint a1, input longint a2,
                          input longint c, input longint s, input int n, input int sh,
                          input string req);
    longint iv[NCH], qv[NCH];
    int t0, t1;
    @(negedge clk);
    ai[0] = a0; ai[1] = a1; ai[2] = a2; ci = c; si = s;
    adc_bus   = {a2[DW-1:0], a1[DW-1:0], a0[DW-1:0]};
    lo_cos    = c[OSCW-1:0];
    lo_sin    = s[OSCW-1:0];
    period    = PERW'(n);
    shift_ctl = 4'(sh);
    while (i_valid) @(negedge clk);
    for (int f = 0; f < 4; f++) frame_both(iv, qv, t0);
    frame_both(iv, qv, t0);
    frame_both(iv, qv, t1);
    chk("R3 frame spacing", longint'(t1 - t0), longint'(n));
    for (int k = 0; k < NCH; k++) begin
      chk(clipped(mixv(ai[k], c), n, sh) ? "R5 i clamp" : {req, " i"}, iv[k], resv(mixv(ai[k], c), n, sh));
      chk(clipped(mixv(ai[k], s), n, sh) ? "R5 q clamp" : {req, " q"}, qv[k], resv(mixv(ai[k], s), n, sh));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint iv[NCH], qv[NCH];
    rst = 1'b1; i_ready = 1'b1; q_ready = 1'b1;
    adc_bus = '0; lo_cos = '0; lo_sin = '0; period = 6'd8; shift_ctl = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 i valid in reset", longint'(i_valid), 0);
    chk("R1 q valid in reset", longint'(q_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 i valid after reset", longint'(i_valid), 0);
    chk("R1 q valid after reset", longint'(q_valid), 0);

    run_case(10, -20, 30, 50, -40, 8, 0, "R4");
    run_case(100, -7, -128, -128, 127, 12, 3, "R2");
    run_case(127, -128, 64, 127, -128, 30, 0, "R5");
    run_case(-1, 1, 0, 5, 7, 5, 15, "R4");
    run_case(90, -90, 45, -100, 100, 63, 5, "R4");
    for (int n = 4; n <= 20; n++) begin
      run_case(longint'(3 * n - 30), longint'(50 - n), longint'(-n),
               60, longint'(n - 70), n, n % 16, "R4");
    end

    // back-pressure on the quadrature stream only
    run_case(10, -20, 30, 50, -40, 20, 0, "R4");
    while (i_valid) @(negedge clk);
    q_ready = 1'b0;
    collect_lane(1'b0, iv);
    for (int k = 0; k < NCH; k++)
      chk("R9 i unaffected by q stall", iv[k], resv(mixv(ai[k], ci), 20, 0));
    chk("R7 q valid held", longint'(q_valid), 1);
    chk("R7 q data held", longint'($signed(q_data)), resv(mixv(ai[0], si), 20, 0));
    q_ready = 1'b1;
    collect_lane(1'b1, qv);
    for (int k = 0; k < NCH; k++)
      chk("R7 q beat after release", qv[k], resv(mixv(ai[k], si), 20, 0));

    // partial drain, then a boundary reloads the full frame
    q_ready = 1'b0;
    while (!q_valid) @(negedge clk);
    chk("R8 q first beat", longint'($signed(q_data)), resv(mixv(ai[0], si), 20, 0));
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
    chk("R7 q second entry waits", longint'($signed(q_data)), resv(mixv(ai[1], si), 20, 0));
    repeat (25) @(negedge clk);
    q_ready = 1'b1;
    collect_lane(1'b1, qv);
    for (int k = 0; k < NCH; k++)
      chk("R8 q reloaded frame", qv[k], resv(mixv(ai[k], si), 20, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule